// File: doc/BRIEF.md
# Supply Low-Voltage Warning Flag Controller

This block holds one byte of control and status for a supply-voltage warning. Four asynchronous digital indications come from outside, one for each trip level. Each indication is high while the supply sits below that level. A two-bit select field picks one of the four. When the chosen indication goes from inactive to active, the block sets a sticky warning flag. If the enable bit is set, the flag also drives a registered level interrupt.

Software reads the whole byte at any time through a plain read port. It writes the byte with a single write strobe, and there is no address. The flag is read-only, and software clears it through a separate acknowledge bit that can only be written. The flag also sets when the selected level is already active as reset ends. It also sets when software switches the select to a level that is already active. After power-up, software should therefore acknowledge the flag before it turns the interrupt on.

Top module: `lvw_ctrl`

## Requirements
- R1: While reset is held and in the cycles after it, with all indications inactive, the byte reads 0x00 and the interrupt is 0. At reset the enable is 0 and the select is 00.
- R2: Each indication passes through two synchronizing flops. Suppose the selected indication rises before clock edge E1. Bit 7 (the flag) still reads 0 after edge E2 and reads 1 after edge E3.
- R3: Suppose the selected indication is already active when reset is released. The flag then reads 1 within four cycles after release.
- R4: A write with bit 6 at 1 clears the flag on that edge. A write with bit 6 at 0 leaves the flag unchanged. Bit 6 always reads 0.
- R5: The interrupt output equals the flag AND the enable (bit 5), delayed by one register: it follows a change of either one edge later.
- R6: Bits 4 to 2 always read 0, and writes to them are ignored. Writes to bit 7 have no effect on the flag.
- R7: Select bits 1:0 hold code k, where k is 0 for low, 1 for mid-1, 2 for mid-2 and 3 for high. With code k, only indication input bit k can set the flag, and the other three inputs are ignored.
- R8: Sometimes a set event and an acknowledge write land on the same edge. The flag then stays 1.
- R9: Writing a select code whose indication is already active sets the flag one edge after the write edge.
- R10: When the selected indication falls, the flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| below_lvl | input | 4 | Asynchronous below-threshold indications, bit k for trip code k |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte: flag, 0, enable, 000, select |
| irq | output | 1 | Registered level interrupt request |

## Verification
Two functions can fall on the same edge: a flag set caused by a crossing and an acknowledge write. The bench counts the synchronizer delay and raises the selected indication so that its set event lands on a known edge. It then issues the acknowledge write in exactly the cycle before that edge. After the edge it judges that the flag stayed 1. A second acknowledge on a quiet cycle must then clear the flag, which shows that the first acknowledge did reach the flag logic and only lost to the set.

// File: rtl/lvw_pkg.sv
package lvw_pkg;

    localparam int LVL_N    = 4;
    localparam int SEL_W    = $clog2(LVL_N);
    localparam int REG_W    = 8;

    localparam int BIT_FLAG = 7;
    localparam int BIT_ACK  = 6;
    localparam int BIT_IE   = 5;

    typedef enum logic [SEL_W-1:0] {
        TRIP_LOW  = 2'd0,
        TRIP_MID1 = 2'd1,
        TRIP_MID2 = 2'd2,
        TRIP_HIGH = 2'd3
    } trip_sel_e;

    typedef struct packed {
        logic      irq_en;
        trip_sel_e sel;
    } lvw_cfg_t;

    localparam lvw_cfg_t CFG_RESET = '{irq_en: 1'b0, sel: TRIP_LOW};

    function automatic logic [REG_W-1:0] pack_status(input logic flag, input lvw_cfg_t cfg);
        logic [REG_W-1:0] b;
        b             = '0;
        b[BIT_FLAG]   = flag;
        b[BIT_IE]     = cfg.irq_en;
        b[SEL_W-1:0]  = cfg.sel;
        return b;
    endfunction

endpackage

// File: rtl/lvw_sync.sv
module lvw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/lvw_cross.sv
module lvw_cross
    import lvw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_N-1:0] lvl_sync,
    input  trip_sel_e        sel,
    output logic             set_evt
);
    logic sel_now;
    logic sel_prev;

    assign sel_now = lvl_sync[sel];

    always_ff @(posedge clk) begin
        if (rst) sel_prev <= 1'b0;
        else     sel_prev <= sel_now;
    end

    assign set_evt = sel_now & ~sel_prev;

    // a set event needs the selected level active right now (R2, R7)
    assert_evt_needs_level_R7: assert property (@(posedge clk) disable iff (rst)
        set_evt |-> lvl_sync[sel]);

    // an event never repeats on consecutive cycles without the select moving (R2)
    assert_evt_single_R2: assert property (@(posedge clk) disable iff (rst)
        (set_evt && $stable(sel)) |=> (!set_evt || sel != $past(sel)));

endmodule

// File: rtl/lvw_regs.sv
module lvw_regs
    import lvw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             set_evt,
    output lvw_cfg_t         cfg,
    output logic             flag,
    output logic             irq,
    output logic [REG_W-1:0] rd_data
);
    logic ack;
    logic unused_wr_bits;

    assign ack            = wr_en & wr_data[BIT_ACK];
    assign unused_wr_bits = ^{wr_data[BIT_FLAG], wr_data[BIT_IE-1:SEL_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_en) begin
            cfg.irq_en <= wr_data[BIT_IE];
            cfg.sel    <= trip_sel_e'(wr_data[SEL_W-1:0]);
        end
    end

    // set has priority over acknowledge
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (ack)     flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= flag & cfg.irq_en;
    end

    assign rd_data = pack_status(flag, cfg);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && !set_evt) |=> !flag);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (!set_evt && !ack) |=> $stable(flag));

    assert_irq_on_R5: assert property (@(posedge clk) disable iff (rst)
        (flag && cfg.irq_en) |=> irq);

    assert_irq_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!flag || !cfg.irq_en) |=> !irq);

endmodule

// File: rtl/lvw_ctrl.sv
module lvw_ctrl
    import lvw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_N-1:0] below_lvl,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    logic [LVL_N-1:0] lvl_sync;
    lvw_cfg_t         cfg;
    logic             set_evt;
    logic             flag;

    lvw_sync #(.WIDTH(LVL_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (below_lvl),
        .q_sync  (lvl_sync)
    );

    lvw_cross u_cross (
        .clk      (clk),
        .rst      (rst),
        .lvl_sync (lvl_sync),
        .sel      (cfg.sel),
        .set_evt  (set_evt)
    );

    lvw_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .set_evt (set_evt),
        .cfg     (cfg),
        .flag    (flag),
        .irq     (irq),
        .rd_data (rd_data)
    );

    // the flag never rises unless a set event preceded it (R2, R3)
    assert_rise_needs_evt_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[BIT_FLAG]) |-> $past(set_evt));

endmodule

// File: tb/test_lvw_ctrl.sv
module test_lvw_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] below_lvl;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [7:0] ACK = 8'h40;
    localparam logic [7:0] IE  = 8'h20;

    always #5 clk = ~clk;

    lvw_ctrl i_lvw_ctrl (
        .clk (clk), .rst (rst), .below_lvl (below_lvl),
        .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data), .irq (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] lvl);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; below_lvl = lvl;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        // R1 reset state
        do_reset(4'h0);
        chk("R1 rd after reset", rd_data, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        cyc(4);
        chk("R1 rd idle", rd_data, 8'h00);

        // R2 R5 R7: sweep select code, enable and driven input bit
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                for (int j = 0; j < 4; j++) begin
                    logic [7:0] cfgb;
                    logic       hit;
                    cfgb = (e != 0 ? IE : 8'h00) | 8'(s);
                    hit  = (j == s);
                    do_reset(4'h0);
                    wr(cfgb);
                    cyc(2);
                    below_lvl = 4'(1 << j);   // before E1
                    cyc(2);                    // after E2
                    chk("R2 flag not yet after two edges", rd_data, cfgb);
                    cyc(1);                    // after E3
                    chk("R7 flag only on selected input", rd_data, cfgb | (hit ? 8'h80 : 8'h00));
                    chk("R5 irq lags flag", {7'b0, irq}, 8'h00);
                    cyc(1);                    // after E4
                    chk("R5 irq = flag & enable", {7'b0, irq}, {7'b0, hit & (e != 0)});
                    // R10 falling level leaves flag unchanged
                    below_lvl = 4'h0;
                    cyc(4);
                    chk("R10 fall keeps flag", rd_data, cfgb | (hit ? 8'h80 : 8'h00));
                    // R4 ack clears
                    wr(cfgb | ACK);
                    chk("R4 ack clears flag", rd_data, cfgb);
                    cyc(1);
                    chk("R5 irq drops after ack", {7'b0, irq}, 8'h00);
                end
            end
        end

        // R3 level already active at reset release
        do_reset(4'h1);
        cyc(4);
        chk("R3 flag set from already-low supply", rd_data, 8'h80);

        // R4 write 0 to ack does nothing; R6 reserved bits and bit 7
        wr(8'h9C);
        chk("R4 R6 write without ack keeps flag, reserved ignored", rd_data, 8'h80);
        wr(ACK);
        chk("R4 ack clears, bit6 reads 0", rd_data, 8'h00);
        below_lvl = 4'h0;
        cyc(3);
        wr(8'hFF);
        chk("R6 reserved read 0, bit7 write no effect", rd_data, 8'h23);
        cyc(3);
        chk("R6 flag still clear", rd_data, 8'h23);

        // R8 set and ack on the same edge
        do_reset(4'h0);
        wr(8'h01);
        cyc(2);
        below_lvl = 4'h2;     // before E1
        cyc(2);               // after E2
        wr(ACK | 8'h01);      // write lands on E3 together with set
        chk("R8 set wins over ack", rd_data, 8'h81);
        wr(ACK | 8'h01);
        chk("R8 later ack clears", rd_data, 8'h01);

        // R9 select moves onto an active level
        do_reset(4'h0);
        below_lvl = 4'h8;
        cyc(5);
        chk("R9 unselected active level ignored", rd_data, 8'h00);
        wr(8'h03);
        chk("R9 not set on write edge", rd_data, 8'h03);
        cyc(1);
        chk("R9 set one edge after select write", rd_data, 8'h83);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cyc(100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule